// File: doc/BRIEF.md
# Pixel Pulse Edge Timestamp Recorder

This block sits behind the discriminators of a small group of pixel cells. Each pixel has one digitised comparator bit. The block keeps a free-running tick counter that advances once per bunch crossing. For every pixel it notes the counter value on which a pulse begins and the value on which it ends. From those two values it derives the pulse width, called the time over threshold, which serves as the charge measurement. Each finished pulse becomes a record made of the pixel address, both stamps and the width. The records leave through a single valid/ready stream, one per transfer.

Each pixel has a mask bit that stops it from producing records. A pulse that outlives the counter range is closed at the largest width the counter can express. When several pixels close on the same tick, the lowest address is sent first and the others wait their turn. The counter can be cleared to zero so that stamps line up with an external time origin.

Top module: `pixel_edge_stamper`

## Requirements
- R1: The tick counter is 0 after reset. It advances by one on every clock. A clock on which `bc_clr` is sampled high makes it 0 on the following clock. A pulse whose first high sample comes k clocks after the clearing edge is stamped with leading time k.
- R2: The leading stamp is the counter value on the clock where the pixel's input is first sampled high. The trailing stamp is the counter value on the first clock where that input is sampled low again.
- R3: `hit_tot` equals `hit_trail` minus `hit_lead` modulo 2^TS_W. For a pulse high for w clocks with w below 2^TS_W-1, this is w, including when the counter wraps during the pulse.
- R4: A pulse that is still high 2^TS_W-1 clocks after its leading stamp is closed on that clock with trailing stamp lead+255 and width 255 (TS_W=8). The continuing high level makes no further record until the input falls and rises again.
- R5: A masked pixel (`mask_in[i]`=1) ignores rising edges. Asserting its mask while a pulse is open discards that pulse, so no record is made. Other pixels are unaffected.
- R6: While a pixel's finished record has not yet moved into the output stage, a new pulse on that pixel is ignored entirely.
- R7: `hit_addr` equals GROUP_BASE plus the index of the pixel's bit in `disc_in`.
- R8: A record appears on `hit_valid` on the second clock after the closing sample if the output stage is free. When several pixels are waiting, they are sent in ascending address order.
- R9: While `hit_valid` is high and `hit_ready` is low, `hit_valid` and all record fields stay unchanged. No record is lost or duplicated.
- R10: After reset, `hit_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bc_clr | input | 1 | Synchronous clear of the tick counter |
| disc_in | input | NPIX | Digitised discriminator level, one bit per pixel |
| mask_in | input | NPIX | Per-pixel hit suppression |
| hit_ready | input | 1 | Downstream can take a record |
| hit_valid | output | 1 | A record is offered |
| hit_addr | output | ADDR_W | Pixel address of the record |
| hit_lead | output | TS_W | Leading-edge stamp |
| hit_trail | output | TS_W | Trailing-edge stamp |
| hit_tot | output | TS_W | Pulse width in ticks |

## Verification
A corrupted counter or stamp register shows up in the very next record as a leading time off from the arithmetic expectation. That is two clocks after the pulse closes. A pixel cell stuck open or stuck pending shows up as a missing record, or as extra records on later pulses of that pixel. Ordering or handshake faults in the output stage show up as addresses out of ascending order, or as fields that change while the stream is stalled. The sweep visits every pixel with many widths, so each of these faults reaches the ports within a few tens of clocks.

// File: rtl/pes_pkg.sv
`timescale 1ns/1ps
package pes_pkg;

  typedef enum logic [1:0] {
    CELL_IDLE = 2'd0,
    CELL_OPEN = 2'd1,
    CELL_PEND = 2'd2
  } cell_st_e;

endpackage

// File: rtl/pes_rst_sync.sv
`timescale 1ns/1ps
module pes_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pes_bc_counter.sv
`timescale 1ns/1ps
module pes_bc_counter #(
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  output logic [TS_W-1:0] bc
);

  logic [TS_W-1:0] bc_q, bc_d;

  always_comb begin
    if (clr) bc_d = '0;
    else     bc_d = bc_q + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bc_q <= '0;
    else        bc_q <= bc_d;
  end

  assign bc = bc_q;

endmodule

// File: rtl/pes_cell.sv
`timescale 1ns/1ps
module pes_cell
  import pes_pkg::*;
#(
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disc,
  input  logic            mask,
  input  logic [TS_W-1:0] bc,
  input  logic            grant,
  output logic            pend,
  output logic [TS_W-1:0] lead,
  output logic [TS_W-1:0] trail
);

  localparam logic [TS_W-1:0] SAT = '1;

  cell_st_e        st_q, st_d;
  logic            disc_q;
  logic [TS_W-1:0] lead_q, lead_d;
  logic [TS_W-1:0] trail_q, trail_d;
  logic            rise;
  logic [TS_W-1:0] elapsed;

  assign rise    = disc && !disc_q;
  assign elapsed = bc - lead_q;

  always_comb begin
    st_d    = st_q;
    lead_d  = lead_q;
    trail_d = trail_q;
    unique case (st_q)
      CELL_IDLE: begin
        if (rise && !mask) begin
          st_d   = CELL_OPEN;
          lead_d = bc;
        end
      end
      CELL_OPEN: begin
        if (mask) begin
          st_d = CELL_IDLE;
        end else if (!disc || (elapsed == SAT)) begin
          st_d    = CELL_PEND;
          trail_d = bc;
        end
      end
      CELL_PEND: begin
        if (grant) st_d = CELL_IDLE;
      end
      default: st_d = CELL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CELL_IDLE;
      disc_q  <= 1'b0;
      lead_q  <= '0;
      trail_q <= '0;
    end else begin
      st_q    <= st_d;
      disc_q  <= disc;
      lead_q  <= lead_d;
      trail_q <= trail_d;
    end
  end

  assign pend  = (st_q == CELL_PEND);
  assign lead  = lead_q;
  assign trail = trail_q;

endmodule

// File: rtl/pes_pick.sv
`timescale 1ns/1ps
module pes_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] oh
);

  logic found;

  always_comb begin
    oh    = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        oh[i] = 1'b1;
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pixel_edge_stamper.sv
`timescale 1ns/1ps
module pixel_edge_stamper #(
  parameter int NPIX       = 16,
  parameter int TS_W       = 8,
  parameter int ADDR_W     = 12,
  parameter int GROUP_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bc_clr,
  input  logic [NPIX-1:0]   disc_in,
  input  logic [NPIX-1:0]   mask_in,
  input  logic              hit_ready,
  output logic              hit_valid,
  output logic [ADDR_W-1:0] hit_addr,
  output logic [TS_W-1:0]   hit_lead,
  output logic [TS_W-1:0]   hit_trail,
  output logic [TS_W-1:0]   hit_tot
);

  localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1;

  logic                 srst_n;
  logic [TS_W-1:0]      bc;
  logic [NPIX-1:0]      pend;
  logic [NPIX-1:0]      pick_oh;
  logic [NPIX-1:0]      grant;
  logic [TS_W-1:0]      lead_v  [NPIX];
  logic [TS_W-1:0]      trail_v [NPIX];

  logic                 load;
  logic [IDX_W-1:0]     sel_idx;
  logic [TS_W-1:0]      sel_lead, sel_trail;

  logic                 v_q, v_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [TS_W-1:0]      lead_q, lead_d;
  logic [TS_W-1:0]      trail_q, trail_d;
  logic [TS_W-1:0]      tot_q, tot_d;

  pes_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pes_bc_counter #(.TS_W(TS_W)) u_bc (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (bc_clr),
    .bc    (bc)
  );

  for (genvar g = 0; g < NPIX; g++) begin : g_cell
    pes_cell #(.TS_W(TS_W)) u_cell (
      .clk   (clk),
      .rst_n (srst_n),
      .disc  (disc_in[g]),
      .mask  (mask_in[g]),
      .bc    (bc),
      .grant (grant[g]),
      .pend  (pend[g]),
      .lead  (lead_v[g]),
      .trail (trail_v[g])
    );
  end

  pes_pick #(.N(NPIX)) u_pick (
    .req (pend),
    .oh  (pick_oh)
  );

  // Output stage accepts a new record when empty or being drained.
  assign load  = (|pend) && (!v_q || hit_ready);
  assign grant = load ? pick_oh : '0;

  always_comb begin
    sel_idx   = '0;
    sel_lead  = '0;
    sel_trail = '0;
    for (int i = 0; i < NPIX; i++) begin
      if (pick_oh[i]) begin
        sel_idx   = IDX_W'(i);
        sel_lead  = lead_v[i];
        sel_trail = trail_v[i];
      end
    end
  end

  always_comb begin
    v_d     = v_q;
    addr_d  = addr_q;
    lead_d  = lead_q;
    trail_d = trail_q;
    tot_d   = tot_q;
    if (load) begin
      v_d     = 1'b1;
      addr_d  = ADDR_W'(GROUP_BASE) + ADDR_W'(sel_idx);
      lead_d  = sel_lead;
      trail_d = sel_trail;
      tot_d   = sel_trail - sel_lead;
    end else if (hit_ready) begin
      v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      v_q     <= 1'b0;
      addr_q  <= '0;
      lead_q  <= '0;
      trail_q <= '0;
      tot_q   <= '0;
    end else begin
      v_q     <= v_d;
      addr_q  <= addr_d;
      lead_q  <= lead_d;
      trail_q <= trail_d;
      tot_q   <= tot_d;
    end
  end

  assign hit_valid = v_q;
  assign hit_addr  = addr_q;
  assign hit_lead  = lead_q;
  assign hit_trail = trail_q;
  assign hit_tot   = tot_q;

endmodule

// File: rtl/pes_sva.sv
`timescale 1ns/1ps
module pes_sva #(
  parameter int NPIX       = 16,
  parameter int TS_W       = 8,
  parameter int ADDR_W     = 12,
  parameter int GROUP_BASE = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bc_clr,
  input logic [TS_W-1:0]   bc,
  input logic [NPIX-1:0]   pend,
  input logic [NPIX-1:0]   grant,
  input logic              hit_ready,
  input logic              hit_valid,
  input logic [ADDR_W-1:0] hit_addr,
  input logic [TS_W-1:0]   hit_lead,
  input logic [TS_W-1:0]   hit_trail,
  input logic [TS_W-1:0]   hit_tot
);

  assert_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bc_clr |=> bc == $past(bc) + TS_W'(1));

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bc_clr |=> bc == '0);

  assert_nonzero_tot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> hit_tot != '0);

  assert_addr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (int'(hit_addr) >= GROUP_BASE) && (int'(hit_addr) < GROUP_BASE + NPIX));

  assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pend) == '0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && !hit_ready |=> hit_valid && $stable(hit_addr) && $stable(hit_lead)
      && $stable(hit_trail) && $stable(hit_tot));

endmodule

bind pixel_edge_stamper pes_sva #(
  .NPIX(NPIX), .TS_W(TS_W), .ADDR_W(ADDR_W), .GROUP_BASE(GROUP_BASE)
) u_sva (
  .clk       (clk),
  .rst_n     (srst_n),
  .bc_clr    (bc_clr),
  .bc        (bc),
  .pend      (pend),
  .grant     (grant),
  .hit_ready (hit_ready),
  .hit_valid (hit_valid),
  .hit_addr  (hit_addr),
  .hit_lead  (hit_lead),
  .hit_trail (hit_trail),
  .hit_tot   (hit_tot)
);

// File: tb/sim_pixel_edge_stamper.sv
`timescale 1ns/1ps
module sim_pixel_edge_stamper;

  localparam int NPIX = 4;
  localparam int TS_W = 8;
  localparam int ADDR_W = 12;
  localparam int BASE = 100;

  logic              clk;
  logic              rst_n;
  logic              bc_clr;
  logic [NPIX-1:0]   disc_in;
  logic [NPIX-1:0]   mask_in;
  logic              hit_ready;
  logic              hit_valid;
  logic [ADDR_W-1:0] hit_addr;
  logic [TS_W-1:0]   hit_lead, hit_trail, hit_tot;

  int checks = 0;
  int failures = 0;
  int rc = 0;
  int r_addr [0:511];
  int r_lead [0:511];
  int r_trail[0:511];
  int r_tot  [0:511];
  logic [TS_W-1:0] now;
  int exp_lead, exp_trail;

  pixel_edge_stamper #(.NPIX(NPIX), .TS_W(TS_W), .ADDR_W(ADDR_W), .GROUP_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .bc_clr(bc_clr), .disc_in(disc_in), .mask_in(mask_in),
    .hit_ready(hit_ready), .hit_valid(hit_valid), .hit_addr(hit_addr),
    .hit_lead(hit_lead), .hit_trail(hit_trail), .hit_tot(hit_tot)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expected counter value during the current cycle (valid after a clear).
  always @(posedge clk) begin
    if (!rst_n)      now <= '0;
    else if (bc_clr) now <= '0;
    else             now <= now + 8'd1;
  end

  always @(negedge clk) begin
    if (rst_n && hit_valid && hit_ready && rc < 512) begin
      r_addr[rc]  = int'(hit_addr);
      r_lead[rc]  = int'(hit_lead);
      r_trail[rc] = int'(hit_trail);
      r_tot[rc]   = int'(hit_tot);
      rc++;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int p, input int w);
    disc_in[p] = 1'b1;
    exp_lead = int'(now);
    repeat (w) tick();
    disc_in[p] = 1'b0;
    exp_trail = int'(now);
  endtask

  task automatic chk_rec(input int k, input int p, input int w, input string req);
    chk(r_addr[k] == BASE + p, {req, " addr"}, r_addr[k], BASE + p);
    chk(r_lead[k] == (exp_lead & 255), {req, " lead"}, r_lead[k], exp_lead & 255);
    chk(r_trail[k] == (exp_trail & 255), {req, " trail"}, r_trail[k], exp_trail & 255);
    chk(r_tot[k] == w, {req, " tot"}, r_tot[k], w);
  endtask

  task automatic clear_bc();
    bc_clr = 1'b1;
    tick();
    bc_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int base_rc;
    int l1, l2;
    rst_n = 1'b0; bc_clr = 1'b0; disc_in = '0; mask_in = '0; hit_ready = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) tick();
    chk(hit_valid == 1'b0, "R10 valid after reset", int'(hit_valid), 0);
    chk(rc == 0, "R10 no record after reset", rc, 0);

    // R1: stamps relative to a clear
    clear_bc();
    repeat (5) tick();
    base_rc = rc;
    pulse(0, 3);
    repeat (3) tick();
    chk(rc == base_rc + 1, "R1 record count", rc, base_rc + 1);
    chk(r_lead[base_rc] == 5, "R1 lead after clear", r_lead[base_rc], 5);
    chk(r_trail[base_rc] == 8, "R2 trail after clear", r_trail[base_rc], 8);

    // R2 R3 R7 R8: sweep over pixels and widths, with latency
    for (int p = 0; p < NPIX; p++) begin
      for (int w = 1; w <= 20; w++) begin
        base_rc = rc;
        pulse(p, w);
        tick();
        chk(hit_valid == 1'b0, "R8 not yet valid", int'(hit_valid), 0);
        tick();
        chk(hit_valid == 1'b1, "R8 valid two clocks after close", int'(hit_valid), 1);
        tick();
        chk(rc == base_rc + 1, "R2 one record", rc, base_rc + 1);
        chk_rec(base_rc, p, w, "R3 R7 sweep");
        tick();
      end
    end

    // R3: wrap of the counter within a pulse
    clear_bc();
    repeat (250) tick();
    base_rc = rc;
    pulse(2, 10);
    repeat (3) tick();
    chk(r_lead[base_rc] == 250, "R3 wrap lead", r_lead[base_rc], 250);
    chk(r_trail[base_rc] == 4, "R3 wrap trail", r_trail[base_rc], 4);
    chk(r_tot[base_rc] == 10, "R3 wrap tot", r_tot[base_rc], 10);

    // R4: saturation
    for (int w = 255; w <= 400; w += 145) begin
      base_rc = rc;
      disc_in[1] = 1'b1;
      exp_lead = int'(now);
      repeat (w) tick();
      disc_in[1] = 1'b0;
      exp_trail = exp_lead + 255;
      repeat (6) tick();
      chk(rc == base_rc + 1, "R4 single record", rc, base_rc + 1);
      chk_rec(base_rc, 1, 255, "R4 saturated");
    end
    base_rc = rc;
    pulse(1, 256);
    exp_trail = exp_lead + 255;
    repeat (6) tick();
    chk(rc == base_rc + 1, "R4 single record 256", rc, base_rc + 1);
    chk_rec(base_rc, 1, 255, "R4 saturated 256");

    // R5: mask at the rising edge, other pixel unaffected
    mask_in = 4'b0100;
    base_rc = rc;
    disc_in = 4'b0101;
    exp_lead = int'(now);
    repeat (4) tick();
    disc_in = 4'b0000;
    exp_trail = int'(now);
    repeat (8) tick();
    chk(rc == base_rc + 1, "R5 masked pixel silent", rc, base_rc + 1);
    chk_rec(base_rc, 0, 4, "R5 unmasked neighbour");
    mask_in = '0;
    // R5: mask raised during an open pulse
    base_rc = rc;
    disc_in[3] = 1'b1;
    repeat (3) tick();
    mask_in[3] = 1'b1;
    tick();
    mask_in[3] = 1'b0;
    repeat (3) tick();
    disc_in[3] = 1'b0;
    repeat (8) tick();
    chk(rc == base_rc, "R5 mid-pulse mask discards", rc, base_rc);

    // R8 R9: simultaneous closes under back-pressure
    hit_ready = 1'b0;
    base_rc = rc;
    disc_in[3] = 1'b1; tick();
    disc_in[1] = 1'b1; tick();
    disc_in[2] = 1'b1; tick(); tick();
    disc_in = '0;
    repeat (3) tick();
    begin
      int a0, l0, t0, o0;
      a0 = int'(hit_addr); l0 = int'(hit_lead); t0 = int'(hit_trail); o0 = int'(hit_tot);
      repeat (5) tick();
      chk(hit_valid == 1'b1, "R9 valid held", int'(hit_valid), 1);
      chk(int'(hit_addr) == a0 && int'(hit_lead) == l0 && int'(hit_trail) == t0
          && int'(hit_tot) == o0, "R9 fields held", int'(hit_addr), a0);
    end
    hit_ready = 1'b1;
    repeat (6) tick();
    chk(rc == base_rc + 3, "R9 three records", rc, base_rc + 3);
    chk(r_addr[base_rc] == BASE + 1, "R8 order first", r_addr[base_rc], BASE + 1);
    chk(r_addr[base_rc + 1] == BASE + 2, "R8 order second", r_addr[base_rc + 1], BASE + 2);
    chk(r_addr[base_rc + 2] == BASE + 3, "R8 order third", r_addr[base_rc + 2], BASE + 3);
    chk(r_tot[base_rc] == 3 && r_tot[base_rc + 1] == 2 && r_tot[base_rc + 2] == 4,
        "R8 widths", r_tot[base_rc], 3);

    // R6: pulse while a record is still pending in the cell
    hit_ready = 1'b0;
    base_rc = rc;
    pulse(0, 2); l1 = exp_lead; repeat (3) tick();
    pulse(0, 3); l2 = exp_lead; repeat (3) tick();
    pulse(0, 4); repeat (3) tick();
    hit_ready = 1'b1;
    repeat (10) tick();
    chk(rc == base_rc + 2, "R6 pending pulse ignored", rc, base_rc + 2);
    chk(r_lead[base_rc] == (l1 & 255) && r_tot[base_rc] == 2, "R6 first record",
        r_lead[base_rc], l1 & 255);
    chk(r_lead[base_rc + 1] == (l2 & 255) && r_tot[base_rc + 1] == 3, "R6 second record",
        r_lead[base_rc + 1], l2 & 255);

    finish_run();
  end

endmodule